// File: doc/BRIEF.md
# Two-Level Predecoded One-Hot Decoder

This block turns a 6-bit binary index into a 64-bit one-hot word. The work happens in two levels. In the first level, the index is cut into three 2-bit slices. Each slice is turned into its own 4-bit one-hot group by a small field decoder. In the second level, a plane of 3-input ANDs builds each output line. Each AND takes exactly one line from each group.

An active-high enable reaches all three field decoders. When the enable is low, every group is empty, so the whole output word is zero. The block has no registers. The output follows the inputs in the same cycle, which makes it suitable for driving word lines or select lines directly.

The slice width and the number of slices are parameters. The defaults give 6 input bits and 64 output lines.

Top module: `pdec_top`

## Requirements
- R1: The index is cut into slices at fixed positions: slice 0 is `addr_i[1:0]`, slice 1 is `addr_i[3:2]` and slice 2 is `addr_i[5:4]`. A change confined to one slice moves the active output line by that slice's value scaled by 1, 4 or 16 respectively.
- R2: Each field decoder maps slice value v to group bit v alone: 00 gives 0001, 01 gives 0010, 10 gives 0100 and 11 gives 1000.
- R3: Output line i equals the AND of three group bits: group 0 bit `i[1:0]`, group 1 bit `i[3:2]` and group 2 bit `i[5:4]`.
- R4: While `en_i` is 0, all 64 output lines are 0 for every index value.
- R5: While `en_i` is 1, exactly one output line is 1, and `dec_o` equals `64'd1 << addr_i` for every one of the 64 index values.
- R6: The block holds no state. A new index or enable value is reflected on `dec_o` within the same cycle it is applied, including when the enable toggles between back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Active-high enable for all field decoders |
| addr_i | input | 6 | Binary index to decode |
| dec_o | output | 64 | One-hot decoded word (all zero when disabled) |

## Verification
Every result of this block is due in the same cycle that its stimulus is applied, because there is no register between `addr_i`/`en_i` and `dec_o`. The bench applies a new stimulus shortly after each rising edge and pushes the matching expected word into a scoreboard queue. The monitor pops that word and compares it at the following falling edge, half a period later, by which time the combinational paths have settled and before the next stimulus arrives. Because exactly one item is driven and one compared per cycle, each comparison lines up with the stimulus that produced it.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    // Default geometry of the decoder
    localparam int SLICE_W_DEF = 2;
    localparam int SLICES_DEF  = 3;

    // Value of slice f within index idx, for slices of width sw
    function automatic int slice_of(input int idx, input int f, input int sw);
        return (idx >> (f * sw)) & ((1 << sw) - 1);
    endfunction

endpackage

// File: rtl/pdec_field.sv
module pdec_field #(
    parameter int SLICE_W = pdec_pkg::SLICE_W_DEF,
    localparam int GRP_W  = 1 << SLICE_W
) (
    input  logic               en_i,
    input  logic [SLICE_W-1:0] fld_i,
    output logic [GRP_W-1:0]   grp_o
);

    // One gate per group line: enable AND a match on the slice value
    for (genvar v = 0; v < GRP_W; v++) begin : g_line
        assign grp_o[v] = en_i & (fld_i == SLICE_W'(v));
    end

endmodule

// File: rtl/pdec_plane.sv
module pdec_plane #(
    parameter int SLICE_W = pdec_pkg::SLICE_W_DEF,
    parameter int SLICES  = pdec_pkg::SLICES_DEF,
    localparam int GRP_W  = 1 << SLICE_W,
    localparam int ADDR_W = SLICE_W * SLICES,
    localparam int OUT_W  = 1 << ADDR_W
) (
    input  logic [SLICES*GRP_W-1:0] grp_i,
    output logic [OUT_W-1:0]        dec_o
);

    // Each output line ANDs one tap taken from every group
    for (genvar i = 0; i < OUT_W; i++) begin : g_out
        logic [SLICES-1:0] taps;
        for (genvar f = 0; f < SLICES; f++) begin : g_tap
            localparam int SEL = pdec_pkg::slice_of(i, f, SLICE_W);
            assign taps[f] = grp_i[f*GRP_W + SEL];
        end
        assign dec_o[i] = &taps;
    end

endmodule

// File: rtl/pdec_top.sv
module pdec_top #(
    parameter int SLICE_W = pdec_pkg::SLICE_W_DEF,
    parameter int SLICES  = pdec_pkg::SLICES_DEF,
    localparam int GRP_W  = 1 << SLICE_W,
    localparam int ADDR_W = SLICE_W * SLICES,
    localparam int OUT_W  = 1 << ADDR_W
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OUT_W-1:0]  dec_o
);

    // Concatenated one-hot groups, group f at [f*GRP_W +: GRP_W]
    logic [SLICES*GRP_W-1:0] grp_w;

    for (genvar f = 0; f < SLICES; f++) begin : g_slice
        pdec_field #(.SLICE_W(SLICE_W)) u_field (
            .en_i  (en_i),
            .fld_i (addr_i[f*SLICE_W +: SLICE_W]),
            .grp_o (grp_w[f*GRP_W +: GRP_W])
        );
    end

    pdec_plane #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_plane (
        .grp_i (grp_w),
        .dec_o (dec_o)
    );

endmodule

// File: rtl/pdec_chk.sv
module pdec_chk #(
    parameter int SLICE_W = pdec_pkg::SLICE_W_DEF,
    parameter int SLICES  = pdec_pkg::SLICES_DEF,
    localparam int GRP_W  = 1 << SLICE_W,
    localparam int ADDR_W = SLICE_W * SLICES,
    localparam int OUT_W  = 1 << ADDR_W
) (
    input logic                    en_i,
    input logic [ADDR_W-1:0]       addr_i,
    input logic [OUT_W-1:0]        dec_o,
    input logic [SLICES*GRP_W-1:0] grp_w
);

    always_comb begin
        if (!en_i) begin
            p_idle_zero_r4: assert (dec_o == '0)
                else $error("R4: output active while disabled");
        end else begin
            p_single_line_r5: assert ($countones(dec_o) == 1)
                else $error("R5: output not one-hot while enabled");
            p_line_at_index_r5: assert (dec_o[addr_i] == 1'b1)
                else $error("R5: indexed line low");
        end
    end

    always_comb begin
        logic [SLICES-1:0] picked;
        for (int f = 0; f < SLICES; f++) begin
            p_group_shape_r2: assert ($countones(grp_w[f*GRP_W +: GRP_W]) == (en_i ? 1 : 0))
                else $error("R2: group %0d malformed", f);
            picked[f] = grp_w[f*GRP_W + int'(addr_i[f*SLICE_W +: SLICE_W])];
        end
        p_plane_uses_groups_r3: assert (dec_o[addr_i] == &picked)
            else $error("R3: output line disagrees with group taps");
    end

endmodule

bind pdec_top pdec_chk #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_chk (
    .en_i   (en_i),
    .addr_i (addr_i),
    .dec_o  (dec_o),
    .grp_w  (grp_w)
);

// File: tb/pdec_top_test.sv
module pdec_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [63:0] dec_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    pdec_top uut (.en_i(en_i), .addr_i(addr_i), .dec_o(dec_o));

    // Driver: apply one stimulus per cycle and queue its expected word
    task automatic drive(input logic en, input logic [5:0] a,
                         input logic [63:0] exp, input string tag);
        @(posedge clk);
        #1;
        en_i   = en;
        addr_i = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Flat reference: 1 << a when enabled
    function automatic logic [63:0] flat_ref(input logic en, input logic [5:0] a);
        return en ? (64'd1 << a) : 64'd0;
    endfunction

    // Predecoded reference built from three independent 4-bit groups (R3)
    function automatic logic [63:0] grp_ref(input logic en, input logic [5:0] a);
        logic [3:0] x, y, z;
        logic [63:0] r;
        x = en ? (4'b0001 << a[1:0]) : 4'b0;
        y = en ? (4'b0001 << a[3:2]) : 4'b0;
        z = en ? (4'b0001 << a[5:4]) : 4'b0;
        for (int i = 0; i < 64; i++)
            r[i] = x[i%4] & y[(i/4)%4] & z[(i/16)%4];
        return r;
    endfunction

    // Monitor: compare at the falling edge, half a cycle after each stimulus
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (dec_o !== e) begin
                    n_fail++;
                    $display("FAIL %s: addr=%0d en=%0b got=%h exp=%h", t, addr_i, en_i, dec_o, e);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: idle inputs give an all-zero word (R4)
        drive(1'b0, 6'd0, 64'd0, "R4 reset");

        // Every index disabled (R4)
        for (int a = 0; a < 64; a++)
            drive(1'b0, 6'(a), 64'd0, "R4 disabled");

        // Every index enabled against the flat shift (R5)
        for (int a = 0; a < 64; a++)
            drive(1'b1, 6'(a), flat_ref(1'b1, 6'(a)), "R5 sweep");

        // Changes confined to one slice; group value v selects bit v (R1, R2)
        for (int f = 0; f < 3; f++)
            for (int v = 0; v < 4; v++)
                drive(1'b1, 6'(v << (2*f)), 64'd1 << (v << (2*f)), "R1 R2 slice walk");

        // Mixed patterns against the three-group AND model (R3)
        for (int k = 0; k < 64; k++) begin
            logic [5:0] a;
            a = 6'((k * 37 + 11) % 64);
            drive(1'b1, a, grp_ref(1'b1, a), "R3 group model");
        end

        // Back-to-back enable toggles at fixed and moving indices (R6)
        for (int k = 0; k < 16; k++) begin
            logic [5:0] a;
            a = 6'(63 - k * 4);
            drive(1'b1, a, flat_ref(1'b1, a), "R6 toggle on");
            drive(1'b0, a, 64'd0, "R6 toggle off");
        end
        drive(1'b1, 6'd63, 64'h8000_0000_0000_0000, "R6 top line");
        drive(1'b1, 6'd0,  64'd1, "R6 bottom line");

        repeat (3) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got=hung exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule